// File: doc/BRIEF.md
# Two-Wire Master SCL Clock Generator

This block produces the serial clock for a two-wire bus master, together with timing strobes for a separate byte engine that shifts the data line. A small prescaler divides the core clock so that one phase lasts a programmable number of core clocks. A four-phase sequencer walks through the phases of each SCL period and decides from the phase whether SCL is driven low or released high.

An 8-bit settings register sets the behaviour. It holds a 6-bit divider and a duty-select bit that picks either an even split or a 75% low / 25% high split. The long-low split suits fast-mode timing. New settings written while the clock runs wait for the next period boundary, so a running period is never distorted. An enable input holds the sequencer idle with SCL high. When enabled, the sequencer always begins a period with its first low phase. It pulses one strobe when each period starts, for launching data, and another when SCL rises, for sampling data.

Top module: `scl_clock_gen`

## Requirements
- R1: The settings register has the divider in bits 5:0 and the duty-select bit in bit 7. Both fields are writable, and a read returns the last written value. Bit 6 always reads 0.
- R2: After reset the register reads 0x00 (even duty, divider 0). SCL is high and both strobes are low.
- R3: While enable is low, SCL is high and both strobes are low. Dropping enable at any point returns SCL high in the first cycle after the clock edge that samples it low.
- R4: In the first cycle after the edge that samples enable high out of idle, SCL is low and a new period begins.
- R5: Each phase lasts exactly DIV+1 core clocks, so one SCL period is 4×(DIV+1) core clocks. For example, DIV=0x06 gives 28 clocks.
- R6: With duty-select 0, each period is two phases low followed by two phases high.
- R7: With duty-select 1, each period is three phases low followed by one phase high.
- R8: The launch strobe is high for exactly one core clock, in the first cycle of each period, while SCL is low.
- R9: The sample strobe is high for exactly one core clock, in the first cycle in which SCL is high within a period.
- R10: A register write takes effect only for periods that begin at least two cycles after the write is driven. A period beginning in the cycle right after the capturing edge still uses the old settings.
- R11: DIV=0 works: the period is 4 core clocks, split 2/2 or 3/1 according to duty-select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the sequencer when high; idle with SCL high when low |
| regWrEn | input | 1 | Write strobe for the settings register |
| regWrData | input | 8 | Write data: bit 7 duty-select, bits 5:0 divider |
| regRdData | output | 8 | Current register contents, bit 6 reads 0 |
| scl | output | 1 | Serial clock level (1 = released high) |
| launchStb | output | 1 | One-cycle pulse at the start of each period |
| sampleStb | output | 1 | One-cycle pulse on the SCL rising edge |

## Verification
Enable and register writes are captured at a rising edge, and their results show in the cycle that follows. SCL and the launch strobe change in the first cycle after enable is sampled. A readback is valid in the cycle after the write edge. A new setting first shapes the period that begins two or more cycles after the write is driven. The bench drives inputs and samples outputs on falling edges, and counts cycles from the edge that samples enable. It steps a model built from the phase length, the duty split and the deferred settings update, and compares SCL and both strobes with the model in every cycle. It also runs a write that lands just before a period boundary, to pin down the deferral edge exactly.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  // Sequencer phases; IDLE holds SCL released
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW_A,
    PH_LOW_B,
    PH_MID,
    PH_HIGH
  } phase_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic running;   // sequencer outside idle
    logic loadCfg;   // latch register settings into the active copy
  } dpCtrl_t;

endpackage

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import sclgen_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [DIV_W+1:0] regWrData,
  output logic [DIV_W+1:0] regRdData,
  input  dpCtrl_t          ctrl,
  output logic             tick,
  output logic             actWide
);
  localparam int WideBit = DIV_W + 1;

  logic [DIV_W-1:0] cfgDiv, actDiv, cnt;
  logic             cfgWide;

  // Software-visible settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDiv  <= '0;
      cfgWide <= 1'b0;
    end else if (regWrEn) begin
      cfgDiv  <= regWrData[DIV_W-1:0];
      cfgWide <= regWrData[WideBit];
    end
  end

  assign regRdData = {cfgWide, 1'b0, cfgDiv};

  // Active copy, refreshed only in idle or at a period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actDiv  <= '0;
      actWide <= 1'b0;
    end else if (ctrl.loadCfg) begin
      actDiv  <= cfgDiv;
      actWide <= cfgWide;
    end
  end

  // Phase prescaler: counts DIV down to zero, tick on zero
  assign tick = ctrl.running && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!ctrl.running) begin
      cnt <= cfgDiv;
    end else if (cnt == '0) begin
      cnt <= ctrl.loadCfg ? cfgDiv : actDiv;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/scl_gen_control.sv
module scl_gen_control
  import sclgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    tick,
  input  logic    actWide,
  output dpCtrl_t ctrl,
  output logic    scl,
  output logic    launchStb,
  output logic    sampleStb
);
  phase_e state, nextState;
  logic   launchNext, sampleNext;

  always_comb begin
    nextState = state;
    if (!enable) begin
      nextState = PH_IDLE;
    end else begin
      unique case (state)
        PH_IDLE:  nextState = PH_LOW_A;
        PH_LOW_A: if (tick) nextState = PH_LOW_B;
        PH_LOW_B: if (tick) nextState = PH_MID;
        PH_MID:   if (tick) nextState = PH_HIGH;
        PH_HIGH:  if (tick) nextState = PH_LOW_A;
        default:  nextState = PH_IDLE;
      endcase
    end
  end

  assign ctrl.running = (state != PH_IDLE);
  assign ctrl.loadCfg = (state == PH_IDLE) || (tick && state == PH_HIGH);

  assign scl = (state == PH_IDLE) || (state == PH_HIGH) ||
               (state == PH_MID && !actWide);

  assign launchNext = (nextState == PH_LOW_A) && (state != PH_LOW_A);
  assign sampleNext = enable && tick &&
                      ((state == PH_LOW_B && !actWide) ||
                       (state == PH_MID && actWide));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      launchStb <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      state     <= nextState;
      launchStb <= launchNext;
      sampleStb <= sampleNext;
    end
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import sclgen_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             regWrEn,
  input  logic [DIV_W+1:0] regWrData,
  output logic [DIV_W+1:0] regRdData,
  output logic             scl,
  output logic             launchStb,
  output logic             sampleStb
);
  dpCtrl_t ctrl;
  logic    tick, actWide;

  scl_gen_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ctrl      (ctrl),
    .tick      (tick),
    .actWide   (actWide)
  );

  scl_gen_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .tick      (tick),
    .actWide   (actWide),
    .ctrl      (ctrl),
    .scl       (scl),
    .launchStb (launchStb),
    .sampleStb (sampleStb)
  );

endmodule

// File: rtl/scl_clock_gen_checker.sv
module scl_clock_gen_checker #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [DIV_W+1:0] regRdData,
  input logic             scl,
  input logic             launchStb,
  input logic             sampleStb
);
  // R3: idle keeps SCL released and strobes quiet
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (scl && !launchStb && !sampleStb));

  // R4: leaving idle starts with a low phase and a launch pulse
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !$past(enable)) |=> (!scl && launchStb));

  // R8: launch only while SCL is low, never two cycles running
  a_r8_launch_low: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |-> !scl);
  a_r8_launch_single: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |=> !launchStb);

  // R9: sample marks the first high cycle
  a_r9_sample_rise: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (scl && !$past(scl)));

  // R8/R9: strobes are never simultaneous
  a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(launchStb && sampleStb));

  // R1: reserved bit stays clear through any write
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regRdData[DIV_W]));
endmodule

bind scl_clock_gen scl_clock_gen_checker #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .regRdData (regRdData),
  .scl       (scl),
  .launchStb (launchStb),
  .sampleStb (sampleStb)
);

// File: tb/test_scl_clock_gen.sv
`timescale 1ns/1ps
module test_scl_clock_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       scl, launchStb, sampleStb;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  // model state
  int mD, mW, pendD, pendW, stgD, stgW, pos;

  always #5 clk = ~clk;

  scl_clock_gen i_scl_clock_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .scl(scl),
    .launchStb(launchStb), .sampleStb(sampleStb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  // write settings, then raise enable; model primed to start at pos 0
  task automatic startRun(input logic [7:0] v);
    writeReg(v);
    pendD = int'(v[5:0]); pendW = int'(v[7]); pos = 0;
    enable = 1'b1;
  endtask

  task automatic stopRun(input string req);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check(scl === 1'b1 && launchStb === 1'b0 && sampleStb === 1'b0, req,
          "idle after disable", {scl, launchStb, sampleStb}, 3'b100);
  endtask

  // step cycle-indexed model; optional write driven in cycle writeAt
  task automatic runModel(input int n, input int writeAt, input logic [7:0] wv,
                          input string reqScl, input string reqSpan);
    int badScl = 0, badL = 0, badS = 0;
    for (int i = 0; i < n; i++) begin
      int per, ph;
      logic eScl, eL, eS;
      @(negedge clk);
      if (pos == 0) begin mD = pendD; mW = pendW; end
      per = 4 * (mD + 1);
      ph  = pos / (mD + 1);
      eScl = (ph == 3) || (ph == 2 && mW == 0);
      eL   = (pos == 0);
      eS   = (pos == ((mW != 0) ? 3 : 2) * (mD + 1));
      if (scl !== eScl)      badScl++;
      if (launchStb !== eL)  badL++;
      if (sampleStb !== eS)  badS++;
      if (writeAt >= 0 && i == writeAt + 1) begin
        pendD = stgD; pendW = stgW; regWrEn = 1'b0;
      end
      if (writeAt >= 0 && i == writeAt) begin
        regWrEn = 1'b1; regWrData = wv;
        stgD = int'(wv[5:0]); stgW = int'(wv[7]);
      end
      pos = (pos + 1) % per;
    end
    check(badScl == 0, reqScl, {"scl shape ", reqSpan}, badScl, 0);
    check(badL == 0, "R8", {"launch strobe ", reqSpan}, badL, 0);
    check(badS == 0, "R9", {"sample strobe ", reqSpan}, badS, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(scl === 1'b1, "R2", "scl in reset", scl, 1);
    check(launchStb === 1'b0 && sampleStb === 1'b0, "R2", "strobes in reset",
          {launchStb, sampleStb}, 0);
    check(regRdData === 8'h00, "R2", "register reset", regRdData, 0);
  endtask

  task automatic t_register;
    writeReg(8'hFF);
    check(regRdData === 8'hBF, "R1", "readback with reserved bit", regRdData, 8'hBF);
    writeReg(8'h31);
    check(regRdData === 8'h31, "R1", "divider readback", regRdData, 8'h31);
    writeReg(8'h80);
    check(regRdData === 8'h80, "R1", "duty bit readback", regRdData, 8'h80);
    check(scl === 1'b1, "R3", "writes while idle leave scl high", scl, 1);
  endtask

  task automatic t_half_duty;  // R5 R6
    startRun(8'h18);
    runModel(200, -1, 8'h00, "R6", "div 0x18 even");
    stopRun("R3");
  endtask

  task automatic t_wide;  // R7
    startRun(8'h87);
    runModel(64, -1, 8'h00, "R7", "div 0x07 long-low");
    stopRun("R3");
  endtask

  task automatic t_div_zero;  // R11
    startRun(8'h00);
    runModel(16, -1, 8'h00, "R11", "div 0 even");
    stopRun("R11");
    startRun(8'h80);
    runModel(16, -1, 8'h00, "R11", "div 0 long-low");
    stopRun("R11");
  endtask

  task automatic t_period;  // R5
    int first = -1, second = -1;
    startRun(8'h06);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (launchStb === 1'b1) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    check(first == 0, "R5", "first launch cycle", first, 0);
    check(second - first == 28, "R5", "period at div 0x06", second - first, 28);
    stopRun("R3");
  endtask

  task automatic t_deferred;  // R10
    startRun(8'h03);
    runModel(48, 5, 8'h81, "R10", "write mid-period");
    stopRun("R3");
    startRun(8'h03);
    runModel(48, 15, 8'h82, "R10", "write at boundary edge");
    stopRun("R3");
  endtask

  task automatic t_disable;  // R3 R4
    startRun(8'h04);
    runModel(7, -1, 8'h00, "R6", "before abort");
    @(negedge clk); enable = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (scl !== 1'b1 || launchStb !== 1'b0 || sampleStb !== 1'b0) bad++;
      end
      check(bad == 0, "R3", "idle cycles after abort", bad, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check(scl === 1'b0, "R4", "scl low on restart", scl, 0);
    check(launchStb === 1'b1, "R4", "launch on restart", launchStb, 1);
    pendD = 4; pendW = 0; pos = 1;
    runModel(39, -1, 8'h00, "R4", "after restart");
    stopRun("R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_register();
    t_half_duty();
    t_wide();
    t_div_zero();
    t_period();
    t_deferred();
    t_disable();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule